// File: doc/BRIEF.md
# Stop-Mode Entry and Wake Sequencer

This block is the low-power controller of a small microcontroller-style system. Software writes a control word that holds a stop bit and a 2-bit wait-select code. Writing the stop bit as 1 while the core is running puts the system into stop mode. In stop mode the main-oscillator enable, the PLL enable and the CPU clock enable all go low. Each shared port/peripheral output pin keeps the peripheral output enable it had at the moment of entry. A pin whose peripheral output was off at that moment therefore floats, and it stays floating for the whole of stop mode.

Stop mode ends on a wake request or when the external reset input goes low. The sequencer then turns the oscillator and the PLL back on and runs one counter that covers both settling times together. The length of that count comes from the stored wait-select code. Any code whose wait is shorter than the PLL settling floor is promoted to the code-10 length. When the count completes, the block raises a one-cycle ready pulse and clears the stop bit in hardware. After a wake request it then restarts the CPU clock. After an external reset it holds the system reset through the whole wait and then through a fixed-length reset sequence, and only then releases the CPU.

Oscillators and the PLL are modelled only as enables. The counter runs on a free-running oscillator-domain clock.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After `rst_n` is released, `osc_en`, `pll_en`, `cpu_clk_en` and `sys_rst_n` are 1, `stop_bit` is 0, `wsel` is 2'b11 and `clk_ready` is 0.
- R2: A write (`ctl_we`=1) while running stores `ctl_wsel` into `wsel`. If `ctl_stop`=1, then from the next cycle `stop_bit`=1 and `osc_en`, `pll_en` and `cpu_clk_en` are all 0. If `ctl_stop`=0, the system keeps running.
- R3: While `stop_bit`=0, `pin_oe` = `port_oe | periph_oe`. While `stop_bit`=1, `pin_oe` equals the `periph_oe` value sampled by the stop write, so a bit that was 0 at entry means a high-impedance pin. Later changes on `port_oe` or `periph_oe` do not reach `pin_oe`.
- R4: A `wake_req` in stop mode turns `osc_en` and `pll_en` on from the next cycle, with `cpu_clk_en` still 0. A single wait of exactly 2^E cycles follows, and `clk_ready` is 1 only in its last cycle.
- R5: Code 00 maps to E=EXP0, 01 to EXP1, 10 to EXP2 and 11 to EXP3 (defaults 10, 13, 15 and 17). A code whose exponent is below MIN_EXP (default 14) is replaced by EXP2.
- R6: After a wait started by `wake_req`, the cycle after `clk_ready` has `stop_bit`=0, `cpu_clk_en`=1 and `sys_rst_n`=1, and `clk_ready` is back to 0.
- R7: Pulling `ext_rst_n` low in stop mode starts the same wait on the next cycle with `sys_rst_n`=0. After `clk_ready`, `stop_bit` clears and `cpu_clk_en`=1 while `sys_rst_n` stays 0 for RST_CYC cycles (default 8), counted once `ext_rst_n` is high. Then `sys_rst_n` returns to 1.
- R8: A `wake_req` during the wait and a write while the system is not running have no effect: the wait length and `wsel` are unchanged.
- R9: `ext_rst_n` low while running drives `sys_rst_n` to 0 from the next cycle. It stays 0 while the input is low and for RST_CYC cycles after release.
- R10: When `ext_rst_n` goes low in the same cycle as a `wake_req` in stop mode, the exit follows R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator-domain clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| ctl_we | input | 1 | Control word write strobe |
| ctl_stop | input | 1 | Stop bit value written |
| ctl_wsel | input | 2 | Wait-select code written |
| wake_req | input | 1 | Wake request from the interrupt side |
| port_oe | input | NPIN | Port output enables of the shared pins |
| periph_oe | input | NPIN | Peripheral output enables of the shared pins |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_rst_n | output | 1 | Reset to the core, active low |
| clk_ready | output | 1 | One-cycle pulse at the end of the settling wait |
| stop_bit | output | 1 | Stop bit readback |
| wsel | output | 2 | Stored wait-select code |
| pin_oe | output | NPIN | Effective output enable of each shared pin (0 = high impedance) |

## Verification
The bench sweeps every wait-select code and measures the exact length of each wait. A design that skipped the promotion, or counted one cycle short or long, would report a length different from 2^E. It sends a wake request in the middle of a wait, and a design that restarted or shortened the count would show a changed length. It changes the pin enables after entry, and a design that did not latch them would let the pins follow the inputs. It holds the external reset low across both the wait and the reset sequence, and makes reset and wake arrive together. A design that released reset together with the stop bit, ended the sequence while the pin was still low, or let wake win over reset would bring the CPU up without reset.

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
  parameter int NPIN    = 16,
  parameter int EXP0    = 10,
  parameter int EXP1    = 13,
  parameter int EXP2    = 15,
  parameter int EXP3    = 17,
  parameter int MIN_EXP = 14,
  parameter int RST_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_rst_n,
  input  logic            ctl_we,
  input  logic            ctl_stop,
  input  logic [1:0]      ctl_wsel,
  input  logic            wake_req,
  input  logic [NPIN-1:0] port_oe,
  input  logic [NPIN-1:0] periph_oe,
  output logic            osc_en,
  output logic            pll_en,
  output logic            cpu_clk_en,
  output logic            sys_rst_n,
  output logic            clk_ready,
  output logic            stop_bit,
  output logic [1:0]      wsel,
  output logic [NPIN-1:0] pin_oe
);
  localparam int CW = EXP3;
  localparam int RW = $clog2(RST_CYC + 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_WAIT, S_RSEQ} st_e;

  st_e             st;
  logic [CW-1:0]   cnt, lim;
  logic [RW-1:0]   rcnt;
  logic            by_rst, stop_q;
  logic [1:0]      wsel_q;
  logic [NPIN-1:0] hold_oe;

  function automatic int code_exp(logic [1:0] c);
    case (c)
      2'b00:   return EXP0;
      2'b01:   return EXP1;
      2'b10:   return EXP2;
      default: return EXP3;
    endcase
  endfunction

  function automatic logic [CW-1:0] wait_lim(logic [1:0] c);
    int e;
    logic [CW:0] t;
    e = code_exp(c);
    if (e < MIN_EXP) e = EXP2;
    t = (CW+1)'(1) << e;
    return CW'(t - (CW+1)'(1));
  endfunction

  assign clk_ready  = (st == S_WAIT) && (cnt == lim);
  assign osc_en     = (st != S_STOP);
  assign pll_en     = (st != S_STOP);
  assign cpu_clk_en = (st == S_RUN) || (st == S_RSEQ);
  assign sys_rst_n  = !((st == S_RSEQ) || ((st == S_WAIT) && by_rst));
  assign stop_bit   = stop_q;
  assign wsel       = wsel_q;
  assign pin_oe     = stop_q ? hold_oe : (port_oe | periph_oe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      stop_q  <= 1'b0;
      wsel_q  <= 2'b11;
      cnt     <= '0;
      lim     <= '0;
      rcnt    <= '0;
      by_rst  <= 1'b0;
      hold_oe <= '0;
    end else begin
      case (st)
        S_RUN:
          if (!ext_rst_n) begin
            st   <= S_RSEQ;
            rcnt <= '0;
          end else if (ctl_we) begin
            wsel_q <= ctl_wsel;
            if (ctl_stop) begin
              stop_q  <= 1'b1;
              st      <= S_STOP;
              lim     <= wait_lim(ctl_wsel);
              hold_oe <= periph_oe;
            end
          end
        S_STOP:
          if (!ext_rst_n || wake_req) begin
            st     <= S_WAIT;
            by_rst <= !ext_rst_n;
            cnt    <= '0;
          end
        S_WAIT: begin
          if (!ext_rst_n) by_rst <= 1'b1;
          if (cnt == lim) begin
            stop_q <= 1'b0;
            rcnt   <= '0;
            st     <= (by_rst || !ext_rst_n) ? S_RSEQ : S_RUN;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_RSEQ:
          if (!ext_rst_n) rcnt <= '0;
          else if (rcnt == RW'(RST_CYC - 1)) st <= S_RUN;
          else rcnt <= rcnt + RW'(1);
        default: st <= S_RUN;
      endcase
    end
  end
endmodule

// File: rtl/stop_wake_ctrl_chk.sv
module stop_wake_ctrl_chk #(
  parameter int NPIN    = 16,
  parameter int MIN_EXP = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            osc_en,
  input logic            pll_en,
  input logic            cpu_clk_en,
  input logic            sys_rst_n,
  input logic            clk_ready,
  input logic            stop_bit,
  input logic [NPIN-1:0] pin_oe
);
  int unsigned wcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wcnt <= 0;
    else if (stop_bit && osc_en) wcnt <= wcnt + 1;
    else wcnt <= 0;

  assert_stop_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_bit) |-> (!osc_en && !pll_en && !cpu_clk_en));

  assert_pins_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_bit && $past(stop_bit)) |-> $stable(pin_oe));

  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ready |=> !clk_ready);

  assert_wait_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ready |-> (wcnt >= (32'd1 << MIN_EXP) - 1));

  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ready |=> (!stop_bit && cpu_clk_en));

  assert_reset_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ready && !sys_rst_n) |=> !sys_rst_n);
endmodule

bind stop_wake_ctrl stop_wake_ctrl_chk #(.NPIN(NPIN), .MIN_EXP(MIN_EXP)) chk_i (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .pll_en(pll_en),
  .cpu_clk_en(cpu_clk_en), .sys_rst_n(sys_rst_n), .clk_ready(clk_ready),
  .stop_bit(stop_bit), .pin_oe(pin_oe)
);

// File: tb/stop_wake_ctrl_test.sv
module stop_wake_ctrl_test;
  localparam int NPIN = 4, E0 = 1, E1 = 2, E2 = 4, E3 = 5, EMIN = 3, RC = 3;

  logic clk = 1'b0, rst_n = 1'b0, ext_rst_n = 1'b1;
  logic ctl_we = 1'b0, ctl_stop = 1'b0, wake_req = 1'b0;
  logic [1:0] ctl_wsel = 2'b00;
  logic [NPIN-1:0] port_oe = '0, periph_oe = '0;
  logic osc_en, pll_en, cpu_clk_en, sys_rst_n, clk_ready, stop_bit;
  logic [1:0] wsel;
  logic [NPIN-1:0] pin_oe;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  stop_wake_ctrl #(.NPIN(NPIN), .EXP0(E0), .EXP1(E1), .EXP2(E2), .EXP3(E3),
                   .MIN_EXP(EMIN), .RST_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .ctl_we(ctl_we),
    .ctl_stop(ctl_stop), .ctl_wsel(ctl_wsel), .wake_req(wake_req),
    .port_oe(port_oe), .periph_oe(periph_oe), .osc_en(osc_en), .pll_en(pll_en),
    .cpu_clk_en(cpu_clk_en), .sys_rst_n(sys_rst_n), .clk_ready(clk_ready),
    .stop_bit(stop_bit), .wsel(wsel), .pin_oe(pin_oe));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(logic [1:0] c);
    int e;
    e = (c == 2'b00) ? E0 : (c == 2'b01) ? E1 : (c == 2'b10) ? E2 : E3;
    if (e < EMIN) e = E2;
    return 1 << e;
  endfunction

  task automatic enter_stop(logic [1:0] c, logic [NPIN-1:0] pat);
    ctl_we = 1'b1; ctl_stop = 1'b1; ctl_wsel = c;
    periph_oe = pat; port_oe = '1;
    tick();
    ctl_we = 1'b0; ctl_stop = 1'b0;
    chk("R2 stop_bit", stop_bit, 1);
    chk("R2 clocks off", {osc_en, pll_en, cpu_clk_en}, 0);
    chk("R2 wsel", wsel, c);
    chk("R3 pin_oe latched", pin_oe, pat);
    periph_oe = ~pat; port_oe = '0;
    ctl_we = 1'b1; ctl_wsel = ~c;
    tick();
    ctl_we = 1'b0;
    chk("R3 pin_oe frozen", pin_oe, pat);
    chk("R8 write ignored in stop", wsel, c);
    chk("R2 still stopped", {stop_bit, osc_en}, 2);
  endtask

  task automatic measure_wait(output int len, input bit rst_exp);
    len = 0;
    forever begin
      len++;
      chk("R4 osc/pll on, cpu off", {osc_en, pll_en, cpu_clk_en}, 6);
      chk("R7 reset during wait", sys_rst_n, rst_exp ? 0 : 1);
      if (clk_ready || len > 200) break;
      wake_req = (len == 3);
      tick();
      wake_req = 1'b0;
    end
  endtask

  task automatic count_rseq(output int n);
    n = 0;
    while (!sys_rst_n && n < 100) begin
      chk("R7 cpu clock during reset seq", cpu_clk_en, 1);
      n++;
      tick();
    end
  endtask

  initial begin
    #(8 * 100000);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int len, n;
    logic [NPIN-1:0] pat;
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 enables", {osc_en, pll_en, cpu_clk_en, sys_rst_n}, 15);
    chk("R1 stop_bit", stop_bit, 0);
    chk("R1 wsel", wsel, 3);
    chk("R1 clk_ready", clk_ready, 0);

    ctl_we = 1'b1; ctl_stop = 1'b0; ctl_wsel = 2'b01;
    tick();
    ctl_we = 1'b0;
    chk("R2 plain write wsel", wsel, 1);
    chk("R2 plain write keeps running", {stop_bit, cpu_clk_en}, 1);

    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 2; p++) begin
        pat = p ? 4'b1010 : 4'b0011;
        enter_stop(2'(c), pat);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        measure_wait(len, 1'b0);
        chk("R4 R5 R8 wait length", len, exp_len(2'(c)));
        tick();
        chk("R6 resumed", {stop_bit, cpu_clk_en, sys_rst_n, clk_ready}, 6);
        periph_oe = pat; port_oe = 4'b0100;
        #1;
        chk("R3 pin_oe after stop", pin_oe, pat | 4'b0100);
      end
    end

    for (int c = 2; c < 4; c++) begin
      for (int hold = 0; hold < 2; hold++) begin
        enter_stop(2'(c), 4'b0110);
        ext_rst_n = 1'b0;
        if (c == 3) wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        if (!hold) ext_rst_n = 1'b1;
        measure_wait(len, 1'b1);
        chk("R7 R10 wait length", len, exp_len(2'(c)));
        tick();
        chk("R7 stop cleared, cpu on", {stop_bit, cpu_clk_en}, 1);
        if (hold) begin
          tick(); tick();
          chk("R7 held while pin low", sys_rst_n, 0);
          ext_rst_n = 1'b1;
        end
        count_rseq(n);
        chk("R7 reset sequence length", n, RC);
        chk("R7 released", {sys_rst_n, cpu_clk_en, stop_bit}, 6);
      end
    end

    ext_rst_n = 1'b0;
    tick();
    chk("R9 reset in run", sys_rst_n, 0);
    tick(); tick(); tick();
    chk("R9 held while low", sys_rst_n, 0);
    ext_rst_n = 1'b1;
    count_rseq(n);
    chk("R9 sequence length", n, RC);
    chk("R9 running", {sys_rst_n, osc_en, stop_bit}, 6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule